// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block feeds one DMA channel from a chain of descriptors held in memory. Software gives it the byte address of the first descriptor and a start pulse. The block then reads the 64-byte descriptor as sixteen 32-bit words over a simple read port with ready/valid handshakes. It keeps the fields it needs and presents the source address, the destination address and the item count of one block to a downstream transfer engine.

When the transfer engine reports that the block is finished, the loader writes the completed item count and the FIFO residue back into the descriptor's two status words. It then raises the block-complete event if the descriptor asked for one, and either loads the next descriptor or ends the chain. A descriptor that is not marked valid stops the chain with an error event. The chain stays stopped, with the offending address visible, until a resume pulse makes the loader read that same descriptor again. A read error on any word aborts the chain with a separate event.

Descriptor layout, in 32-bit words from the aligned base: word 0 source address, word 2 destination address, word 4 item count minus one, word 6 next pointer (byte address divided by 64, held in bits 25:0), word 9 control flags, word 12 completed item count, word 13 FIFO residue. The other words are read and discarded.

Top module: `dfe_top`

## Requirements
- R1: After reset the loader is idle: `busy`, `rd_req_valid`, `blk_valid`, `wr_valid` and all four event outputs are 0. While idle it issues no read, block or write.
- R2: A fetch issues sixteen reads at base, base+4, ..., base+60 in ascending order, where base is `head_ptr` with bits 5:0 cleared. A request that is not accepted holds its address.
- R3: After a valid descriptor is fetched, `blk_valid` is 1 with `blk_src` = word 0, `blk_dst` = word 2, `blk_items` = word 4 plus one and `blk_ioc` = word 9 bit 2. These stay stable until `blk_done`.
- R4: If word 9 bit 0 (valid) is 0, `ev_invalid` pulses for one cycle, no block is presented, `busy` stays 1 and `cur_desc_addr` shows the descriptor's base address.
- R5: A `resume_req` pulse while stalled re-reads all sixteen words of the same descriptor and continues the chain with the refreshed contents.
- R6: After `blk_done`, the loader writes `done_items` to base+48 and then the zero-extended `fifo_left` to base+52, in that order. Each write is held until `wr_ready`.
- R7: If the descriptor is not last and its next pointer field is non-zero, the next fetch starts at that field shifted left by six.
- R8: If word 9 bit 1 (last) is 1 or the next pointer field is 0, `ev_xfer_done` pulses for one cycle after the second write-back and the loader returns to idle.
- R9: When `blk_ioc` is 1, `ev_blk_done` pulses in the cycle that follows the second write-back acceptance. For a final descriptor this is the same cycle as `ev_xfer_done`. When `blk_ioc` is 0, `ev_blk_done` does not pulse.
- R10: If any of the sixteen read responses carries `rd_rsp_err`, the loader still accepts all sixteen responses. It then pulses `ev_fetch_err`, presents no block and returns to idle.
- R11: A `start` pulse while `busy` is 1 is ignored. No read of the new head address is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a chain at `head_ptr` (idle only) |
| head_ptr | input | 32 | Byte address of first descriptor |
| resume_req | input | 1 | Refetch a stalled invalid descriptor |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_addr | output | 32 | Read byte address |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response data |
| rd_rsp_err | input | 1 | Read response error |
| rd_rsp_ready | output | 1 | Loader accepts responses |
| blk_valid | output | 1 | Block parameters valid for the transfer engine |
| blk_src | output | 32 | Block source address |
| blk_dst | output | 32 | Block destination address |
| blk_items | output | 32 | Block item count |
| blk_ioc | output | 1 | Block requests a completion event |
| blk_done | input | 1 | Transfer engine finished the block |
| done_items | input | 32 | Items completed by the engine |
| fifo_left | input | FIFO_W | Data left in the channel FIFO |
| wr_valid | output | 1 | Status write valid |
| wr_addr | output | 32 | Status write byte address |
| wr_data | output | 32 | Status write data |
| wr_ready | input | 1 | Status write accepted |
| ev_blk_done | output | 1 | Block-complete event pulse |
| ev_xfer_done | output | 1 | Chain-complete event pulse |
| ev_invalid | output | 1 | Invalid-descriptor event pulse |
| ev_fetch_err | output | 1 | Descriptor read error event pulse |
| cur_desc_addr | output | 32 | Base address of current descriptor |
| busy | output | 1 | Loader not idle |

## Verification
The block-complete event and the chain-complete event are produced by separate decisions. One comes from the descriptor's interrupt flag and the other from its last flag or a zero next pointer, and both fall in the same cycle when a final descriptor also requests an interrupt. The bench provokes this with a single last descriptor that has the interrupt flag set. It also provokes it at the end of a two-descriptor chain whose final entry ends on a zero next pointer. The event monitor counts cycles in which both pulses are high and expects exactly one such cycle per chain. In a chain whose first descriptor has the flag clear, the monitor expects the block-complete pulse only on the final block.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned DESC_BYTES = 64;
  localparam int unsigned ALIGN_SH   = $clog2(DESC_BYTES);
  localparam int unsigned DESC_WORDS = DESC_BYTES / 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  localparam int unsigned NEXT_W     = ADDR_W - ALIGN_SH;

  // word positions inside a descriptor
  localparam logic [IDX_W-1:0] W_SRC  = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_DST  = IDX_W'(2);
  localparam logic [IDX_W-1:0] W_SIZE = IDX_W'(4);
  localparam logic [IDX_W-1:0] W_NEXT = IDX_W'(6);
  localparam logic [IDX_W-1:0] W_CTRL = IDX_W'(9);
  localparam int unsigned      W_STAT_ITEMS = 12;
  localparam int unsigned      W_STAT_FIFO  = 13;

  // flag bits in the control word
  localparam int unsigned F_VALID = 0;
  localparam int unsigned F_LAST  = 1;
  localparam int unsigned F_IOC   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_RUN, ST_WB_LO, ST_WB_HI, ST_STALL
  } ldr_state_e;

  function automatic logic [ADDR_W-1:0] desc_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:ALIGN_SH], {ALIGN_SH{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] next_to_addr(input logic [NEXT_W-1:0] f);
    return {f, {ALIGN_SH{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] item_count(input logic [DATA_W-1:0] f);
    return f + DATA_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input int unsigned idx);
    return base + ADDR_W'(idx * 4);
  endfunction
endpackage

// File: rtl/dfe_reader.sv
module dfe_reader
  import dfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              rd_rsp_ready,
  output logic              word_we,
  output logic [IDX_W-1:0]  word_idx,
  output logic [DATA_W-1:0] word_data,
  output logic              fetch_done,
  output logic              fetch_bad
);
  logic              active_q;
  logic [IDX_W:0]    req_cnt_q;
  logic [IDX_W:0]    rsp_cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              err_q;
  logic              rsp_hs;
  logic              req_hs;

  assign rd_req_valid = active_q && (req_cnt_q < (IDX_W+1)'(DESC_WORDS));
  assign rd_req_addr  = word_addr(base_q, int'(req_cnt_q));
  assign rd_rsp_ready = active_q;
  assign req_hs       = rd_req_valid && rd_req_ready;
  assign rsp_hs       = active_q && rd_rsp_valid;

  assign word_we    = rsp_hs;
  assign word_idx   = rsp_cnt_q[IDX_W-1:0];
  assign word_data  = rd_rsp_data;
  assign fetch_done = rsp_hs && (rsp_cnt_q == (IDX_W+1)'(DESC_WORDS-1));
  assign fetch_bad  = err_q || rd_rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      req_cnt_q <= '0;
      rsp_cnt_q <= '0;
      base_q    <= '0;
      err_q     <= 1'b0;
    end else if (launch) begin
      active_q  <= 1'b1;
      req_cnt_q <= '0;
      rsp_cnt_q <= '0;
      base_q    <= base;
      err_q     <= 1'b0;
    end else begin
      if (req_hs) req_cnt_q <= req_cnt_q + 1'b1;
      if (rsp_hs) begin
        rsp_cnt_q <= rsp_cnt_q + 1'b1;
        err_q     <= err_q || rd_rsp_err;
        if (fetch_done) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dfe_capture.sv
module dfe_capture
  import dfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] word_data,
  output logic [ADDR_W-1:0] d_src,
  output logic [ADDR_W-1:0] d_dst,
  output logic [DATA_W-1:0] d_size,
  output logic [NEXT_W-1:0] d_next,
  output logic              d_valid,
  output logic              d_last,
  output logic              d_ioc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_src   <= '0;
      d_dst   <= '0;
      d_size  <= '0;
      d_next  <= '0;
      d_valid <= 1'b0;
      d_last  <= 1'b0;
      d_ioc   <= 1'b0;
    end else if (word_we) begin
      unique case (word_idx)
        W_SRC:  d_src  <= word_data;
        W_DST:  d_dst  <= word_data;
        W_SIZE: d_size <= word_data;
        W_NEXT: d_next <= word_data[NEXT_W-1:0];
        W_CTRL: begin
          d_valid <= word_data[F_VALID];
          d_last  <= word_data[F_LAST];
          d_ioc   <= word_data[F_IOC];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dfe_ctrl.sv
module dfe_ctrl
  import dfe_pkg::*;
#(
  parameter int unsigned FIFO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_ptr,
  input  logic              resume_req,
  input  logic              fetch_done,
  input  logic              fetch_bad,
  input  logic              d_valid,
  input  logic              d_last,
  input  logic              d_ioc,
  input  logic [NEXT_W-1:0] d_next,
  input  logic              blk_done,
  input  logic [DATA_W-1:0] done_items,
  input  logic [FIFO_W-1:0] fifo_left,
  input  logic              wr_ready,
  output logic              launch,
  output logic [ADDR_W-1:0] fetch_base,
  output logic              blk_valid,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ev_blk_done,
  output logic              ev_xfer_done,
  output logic              ev_invalid,
  output logic              ev_fetch_err,
  output logic [ADDR_W-1:0] cur_desc_addr,
  output logic              busy
);
  ldr_state_e        state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [DATA_W-1:0] items_q;
  logic [FIFO_W-1:0] left_q;
  logic              chain_end;

  assign chain_end     = d_last || (d_next == '0);
  assign blk_valid     = (state_q == ST_RUN);
  assign wr_valid      = (state_q == ST_WB_LO) || (state_q == ST_WB_HI);
  assign wr_addr       = word_addr(cur_q, (state_q == ST_WB_HI) ? W_STAT_FIFO : W_STAT_ITEMS);
  assign wr_data       = (state_q == ST_WB_HI) ? DATA_W'(left_q) : items_q;
  assign cur_desc_addr = cur_q;
  assign busy          = (state_q != ST_IDLE);

  always_comb begin
    launch     = 1'b0;
    fetch_base = cur_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        launch     = 1'b1;
        fetch_base = desc_base(head_ptr);
      end
      ST_STALL: if (resume_req) launch = 1'b1;
      ST_WB_HI: if (wr_ready && !chain_end) begin
        launch     = 1'b1;
        fetch_base = next_to_addr(d_next);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_q        <= '0;
      items_q      <= '0;
      left_q       <= '0;
      ev_blk_done  <= 1'b0;
      ev_xfer_done <= 1'b0;
      ev_invalid   <= 1'b0;
      ev_fetch_err <= 1'b0;
    end else begin
      ev_blk_done  <= 1'b0;
      ev_xfer_done <= 1'b0;
      ev_invalid   <= 1'b0;
      ev_fetch_err <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          cur_q   <= fetch_base;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (fetch_done) begin
          if (fetch_bad) begin
            ev_fetch_err <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!d_valid) begin
            ev_invalid <= 1'b1;
            state_q    <= ST_STALL;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (blk_done) begin
          items_q <= done_items;
          left_q  <= fifo_left;
          state_q <= ST_WB_LO;
        end
        ST_WB_LO: if (wr_ready) state_q <= ST_WB_HI;
        ST_WB_HI: if (wr_ready) begin
          ev_blk_done <= d_ioc;
          if (chain_end) begin
            ev_xfer_done <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            cur_q   <= fetch_base;
            state_q <= ST_FETCH;
          end
        end
        ST_STALL: if (resume_req) state_q <= ST_FETCH;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dfe_top.sv
module dfe_top
  import dfe_pkg::*;
#(
  parameter int unsigned FIFO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       head_ptr,
  input  logic              resume_req,
  output logic              rd_req_valid,
  output logic [31:0]       rd_req_addr,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              rd_rsp_ready,
  output logic              blk_valid,
  output logic [31:0]       blk_src,
  output logic [31:0]       blk_dst,
  output logic [31:0]       blk_items,
  output logic              blk_ioc,
  input  logic              blk_done,
  input  logic [31:0]       done_items,
  input  logic [FIFO_W-1:0] fifo_left,
  output logic              wr_valid,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ready,
  output logic              ev_blk_done,
  output logic              ev_xfer_done,
  output logic              ev_invalid,
  output logic              ev_fetch_err,
  output logic [31:0]       cur_desc_addr,
  output logic              busy
);
  // internal events, named for the checker
  logic              fetch_done_w;
  logic              fetch_bad_w;
  logic              launch_w;
  logic [ADDR_W-1:0] fetch_base_w;
  logic              word_we_w;
  logic [IDX_W-1:0]  word_idx_w;
  logic [DATA_W-1:0] word_data_w;
  logic [DATA_W-1:0] d_size_w;
  logic [NEXT_W-1:0] d_next_w;
  logic              d_valid_w;
  logic              d_last_w;

  dfe_reader u_reader (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch_w),
    .base         (fetch_base_w),
    .rd_req_valid (rd_req_valid),
    .rd_req_addr  (rd_req_addr),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .rd_rsp_err   (rd_rsp_err),
    .rd_rsp_ready (rd_rsp_ready),
    .word_we      (word_we_w),
    .word_idx     (word_idx_w),
    .word_data    (word_data_w),
    .fetch_done   (fetch_done_w),
    .fetch_bad    (fetch_bad_w)
  );

  dfe_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_we   (word_we_w),
    .word_idx  (word_idx_w),
    .word_data (word_data_w),
    .d_src     (blk_src),
    .d_dst     (blk_dst),
    .d_size    (d_size_w),
    .d_next    (d_next_w),
    .d_valid   (d_valid_w),
    .d_last    (d_last_w),
    .d_ioc     (blk_ioc)
  );

  assign blk_items = item_count(d_size_w);

  dfe_ctrl #(.FIFO_W(FIFO_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .head_ptr      (head_ptr),
    .resume_req    (resume_req),
    .fetch_done    (fetch_done_w),
    .fetch_bad     (fetch_bad_w),
    .d_valid       (d_valid_w),
    .d_last        (d_last_w),
    .d_ioc         (blk_ioc),
    .d_next        (d_next_w),
    .blk_done      (blk_done),
    .done_items    (done_items),
    .fifo_left     (fifo_left),
    .wr_ready      (wr_ready),
    .launch        (launch_w),
    .fetch_base    (fetch_base_w),
    .blk_valid     (blk_valid),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ev_blk_done   (ev_blk_done),
    .ev_xfer_done  (ev_xfer_done),
    .ev_invalid    (ev_invalid),
    .ev_fetch_err  (ev_fetch_err),
    .cur_desc_addr (cur_desc_addr),
    .busy          (busy)
  );
endmodule

// File: rtl/dfe_chk.sv
module dfe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_req_addr,
  input logic        blk_valid,
  input logic        blk_done,
  input logic [31:0] blk_src,
  input logic [31:0] blk_items,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        ev_invalid,
  input logic        ev_xfer_done,
  input logic        ev_fetch_err,
  input logic        fetch_done_w,
  input logic        fetch_bad_w
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !blk_valid && !wr_valid));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R3
  blk_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_done) |=> (blk_valid && $stable(blk_src) && $stable(blk_items)));

  // R4
  invalid_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_invalid |-> (!blk_valid && busy));

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done |-> !busy);

  // R10
  fetch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done_w && fetch_bad_w) |=> (ev_fetch_err && !blk_valid && !busy));
endmodule

bind dfe_top dfe_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .blk_valid    (blk_valid),
  .blk_done     (blk_done),
  .blk_src      (blk_src),
  .blk_items    (blk_items),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .ev_invalid   (ev_invalid),
  .ev_xfer_done (ev_xfer_done),
  .ev_fetch_err (ev_fetch_err),
  .fetch_done_w (fetch_done_w),
  .fetch_bad_w  (fetch_bad_w)
);

// File: tb/tb_dfe_top.sv
`timescale 1ns/1ps
module tb_dfe_top;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 0, resume_req = 0;
  logic [31:0] head_ptr = 0;
  logic        rd_req_valid, rd_rsp_ready;
  logic [31:0] rd_req_addr;
  logic        rd_req_ready = 1;
  logic        rd_rsp_valid = 0, rd_rsp_err = 0;
  logic [31:0] rd_rsp_data = 0;
  logic        blk_valid, blk_ioc;
  logic [31:0] blk_src, blk_dst, blk_items;
  logic        blk_done = 0;
  logic [31:0] done_items = 0;
  logic [FW-1:0] fifo_left = 0;
  logic        wr_valid;
  logic [31:0] wr_addr, wr_data;
  logic        wr_ready = 1;
  logic        ev_blk_done, ev_xfer_done, ev_invalid, ev_fetch_err, busy;
  logic [31:0] cur_desc_addr;

  dfe_top #(.FIFO_W(FW)) dut (.*);

  // bench state
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:63];
  logic [31:0] wr_alog [0:15];
  logic [31:0] src_log [0:7];
  logic [31:0] items_log [0:7];
  int rd_n, wr_n, blk_n, n_bd, n_xd, n_inv, n_ferr, n_both;
  logic slow = 0, err_en = 0;
  logic [31:0] err_addr = 0;
  logic [FW-1:0] fifo_val = 0;
  int eng_wait;
  int total = 0, bad = 0;
  bit finished = 0;

  // memory model: one-cycle read latency, optional request stalls
  always @(posedge clk) begin
    rd_rsp_valid <= 1'b0;
    rd_rsp_err   <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_req_addr[9:2]];
      rd_rsp_err   <= err_en && (rd_req_addr == err_addr);
      if (rd_n < 64) rd_log[rd_n] <= rd_req_addr;
      rd_n <= rd_n + 1;
    end
    if (wr_valid && wr_ready) begin
      mem[wr_addr[9:2]] <= wr_data;
      if (wr_n < 16) wr_alog[wr_n] <= wr_addr;
      wr_n <= wr_n + 1;
    end
    rd_req_ready <= slow ? ~rd_req_ready : 1'b1;
    wr_ready     <= slow ? ~wr_ready : 1'b1;
  end

  // transfer engine model
  always @(posedge clk) begin
    blk_done <= 1'b0;
    if (blk_valid && !blk_done) begin
      if (eng_wait == 2) begin
        blk_done   <= 1'b1;
        done_items <= blk_items;
        fifo_left  <= fifo_val;
        if (blk_n < 8) begin
          src_log[blk_n]   <= blk_src;
          items_log[blk_n] <= blk_items;
        end
        blk_n    <= blk_n + 1;
        eng_wait <= 0;
      end else eng_wait <= eng_wait + 1;
    end else eng_wait <= 0;
  end

  // event monitor
  always @(posedge clk) begin
    if (ev_blk_done) n_bd <= n_bd + 1;
    if (ev_xfer_done) n_xd <= n_xd + 1;
    if (ev_invalid) n_inv <= n_inv + 1;
    if (ev_fetch_err) n_ferr <= n_ferr + 1;
    if (ev_blk_done && ev_xfer_done) n_both <= n_both + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    rd_n = 0; wr_n = 0; blk_n = 0;
    n_bd = 0; n_xd = 0; n_inv = 0; n_ferr = 0; n_both = 0;
    err_en = 0; slow = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  // ctrl word: bit0 valid, bit1 last, bit2 ioc
  task automatic put_desc(input logic [31:0] base, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] sz,
                          input logic [25:0] nxt, input logic [2:0] ctl);
    int b = int'(base[9:2]);
    for (int i = 0; i < 16; i++) mem[b+i] = 32'hA500_0000 | i;
    mem[b+0] = src; mem[b+2] = dst; mem[b+4] = sz;
    mem[b+6] = {6'h3F, nxt};
    mem[b+9] = {29'h0, ctl};
  endtask

  task automatic pulse_start(input logic [31:0] hp);
    @(negedge clk); head_ptr = hp; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic test_reset();
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 rd_req_valid", {31'b0, rd_req_valid}, 0);
    chk("R1 blk_valid", {31'b0, blk_valid}, 0);
    chk("R1 wr_valid", {31'b0, wr_valid}, 0);
    chk("R1 events", {28'b0, ev_blk_done, ev_xfer_done, ev_invalid, ev_fetch_err}, 0);
  endtask

  task automatic test_single();
    clear_logs();
    put_desc(32'h40, 32'h1000_0000, 32'h2000_0000, 32'd9, 26'h3, 3'b111);
    fifo_val = 16'd5;
    slow = 1;
    pulse_start(32'h4C);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (blk_valid) break;
    end
    chk("R3 blk_src", blk_src, 32'h1000_0000);
    chk("R3 blk_dst", blk_dst, 32'h2000_0000);
    chk("R3 blk_items", blk_items, 32'd10);
    chk("R3 blk_ioc", {31'b0, blk_ioc}, 1);
    pulse_start(32'h80);  // R11 ignored while busy
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R2 read count", rd_n, 16);
    for (int i = 0; i < 16; i++) chk("R2 read address", rd_log[i], 32'h40 + 4*i);
    chk("R11 no read of new head", rd_n, 16);
    chk("R6 first write addr", wr_alog[0], 32'h70);
    chk("R6 second write addr", wr_alog[1], 32'h74);
    chk("R6 items written", mem[(32'h40>>2)+12], 32'd10);
    chk("R6 fifo written", mem[(32'h40>>2)+13], 32'd5);
    chk("R8 xfer done count", n_xd, 1);
    chk("R9 blk done count", n_bd, 1);
    chk("R9 same-cycle events", n_both, 1);
    chk("R8 idle", {31'b0, busy}, 0);
  endtask

  task automatic test_chain();
    clear_logs();
    put_desc(32'h00, 32'h0000_1111, 32'h0000_2222, 32'd3, 26'h2, 3'b001);
    put_desc(32'h80, 32'h0000_3333, 32'h0000_4444, 32'd0, 26'h0, 3'b101);
    fifo_val = 16'd0;
    pulse_start(32'h00);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R7 reads for two descriptors", rd_n, 32);
    chk("R7 second fetch base", rd_log[16], 32'h80);
    chk("R7 second fetch end", rd_log[31], 32'hBC);
    chk("R7 block count", blk_n, 2);
    chk("R3 first src", src_log[0], 32'h0000_1111);
    chk("R3 second items", items_log[1], 32'd1);
    chk("R9 ioc only on second", n_bd, 1);
    chk("R8 end on zero next", n_xd, 1);
    chk("R9 coincident at end", n_both, 1);
    chk("R6 second desc items", mem[(32'h80>>2)+12], 32'd1);
  endtask

  task automatic test_invalid();
    clear_logs();
    put_desc(32'hC0, 32'h0000_5555, 32'h0000_6666, 32'd7, 26'h0, 3'b010);
    pulse_start(32'hC0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (n_inv != 0) break;
    end
    repeat (30) @(negedge clk);
    chk("R4 invalid event", n_inv, 1);
    chk("R4 no block", blk_n, 0);
    chk("R4 still busy", {31'b0, busy}, 1);
    chk("R4 offending address", cur_desc_addr, 32'hC0);
    chk("R4 no extra reads", rd_n, 16);
    mem[(32'hC0>>2)+9] = 32'h3;
    mem[(32'hC0>>2)+0] = 32'h0000_7777;
    @(negedge clk); resume_req = 1;
    @(negedge clk); resume_req = 0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R5 refetch reads", rd_n, 32);
    chk("R5 refetch base", rd_log[16], 32'hC0);
    chk("R5 refreshed src", src_log[0], 32'h0000_7777);
    chk("R5 chain completes", n_xd, 1);
    chk("R9 no ioc event", n_bd, 0);
  endtask

  task automatic test_fetch_err();
    clear_logs();
    put_desc(32'h100, 32'h1, 32'h2, 32'd4, 26'h0, 3'b011);
    err_en = 1; err_addr = 32'h114;
    pulse_start(32'h100);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R10 fetch error event", n_ferr, 1);
    chk("R10 all responses read", rd_n, 16);
    chk("R10 no block", blk_n, 0);
    chk("R10 no writes", wr_n, 0);
    chk("R10 no done", n_xd, 0);
    chk("R10 idle", {31'b0, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_single();
    test_chain();
    test_invalid();
    test_fetch_err();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule